// File: doc/BRIEF.md
# Programmable Countdown Timer with One-Shot and Periodic Modes

This block is a per-core countdown timer controlled through a single 64-bit configuration word. Software writes the word to arm, re-arm or stop the timer. Once armed, the timer counts down once for each cycle in which the tick-enable input is high. When the count runs out it raises a level interrupt. It then either reloads itself from the stored word (periodic mode) or clears its own enable bit and stops (one-shot mode). The configuration word can be read back at any time, and a separate output always shows how many ticks remain before the next expiry.

The tick-enable input is normally driven by a divider that produces one pulse per 10 ns, which gives a 100 MHz count rate. The control logic is a two-state machine. In `IDLE`, nothing counts and the remaining count reads zero. In `RUN`, the counter decrements on each tick. The machine has these transitions:
- *arm*: `IDLE`→`RUN`, on a write with enable set.
- *restart*: `RUN`→`RUN`, on a write with enable set.
- *reload*: `RUN`→`RUN`, on a periodic expiry.
- *halt*: `RUN`→`IDLE`, on a write with enable clear.
- *expire-once*: `RUN`→`IDLE`, on a one-shot expiry.

The interrupt is held in a separate latch and stays high until the clear input is pulsed.

Top module: `cd_timer`

## Requirements
- R1: After reset, `cfg_rdata`, `remain` and `irq` are all zero.
- R2: Word layout. Bit 0 is enable and bit 1 is periodic mode. The start count is bits 47:2 of the word with bits 1:0 forced to zero. Bits 63:48 have no effect on counting, but all 64 bits are stored and returned on `cfg_rdata`.
- R3: A write with enable set shows the masked count on `remain` in the cycle after the write. This overrides any countdown in progress, and it also overrides a tick or expiry in the same cycle.
- R4: While running, each cycle with `tick_en` high lowers `remain` by one. A cycle with `tick_en` low leaves `remain` unchanged.
- R5: A tick that arrives while running with `remain` at 1 or 0 is an expiry. A start count of zero therefore expires on the first tick.
- R6: A periodic expiry reloads `remain` from bits 47:2 of the stored word, and the timer keeps running.
- R7: A one-shot expiry clears bit 0 of the stored word, sets `remain` to zero and stops the timer.
- R8: A write with enable clear sets `remain` to zero in the next cycle. No expiry or interrupt follows until the timer is armed again.
- R9: Every expiry drives `irq` high in the next cycle. `irq` stays high until a cycle with `irq_clr` high. If an expiry and a clear fall in the same cycle, the expiry wins and `irq` stays high.
- R10: While the timer is stopped, `remain` reads zero and ticks change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | Configuration word to write |
| tick_en | input | 1 | Count enable, one cycle per tick |
| irq_clr | input | 1 | Interrupt clear pulse |
| cfg_rdata | output | 64 | Stored configuration word |
| remain | output | 48 | Ticks left before the next expiry |
| irq | output | 1 | Level timer interrupt |

## Verification
A wrong state in the machine shows up on `remain` in the very next cycle. A timer stuck in `RUN` keeps a nonzero count after a halt, and a timer stuck in `IDLE` reads zero after arming. A wrong count or reload value shows up as an early or late `irq` edge, so it is visible at most one period later. A missed enable-bit clear appears on `cfg_rdata` in the cycle after a one-shot expiry. The bench compares all three outputs against a reference model after every clock. It uses random writes, ticks and clears, together with directed cases for zero counts, the high bits and clear-versus-expiry collisions.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cdt_state_e;
endpackage

// File: rtl/cdt_cfg_reg.sv
module cdt_cfg_reg #(
    parameter int CFG_W  = 64,
    parameter int EN_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             drop_en,
    output logic [CFG_W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end else if (drop_en) begin
            cfg_q[EN_BIT] <= 1'b0;
        end
    end

    // R7
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en && !we) |=> !cfg_q[EN_BIT]);

    // R2
    store_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cfg_q == $past(wdata));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int CW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          stop,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    input  logic          periodic,
    input  logic          tick,
    output logic          expire,
    output logic [CW-1:0] remain
);
    cdt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last;

    assign last = (cnt_q <= CW'(1));

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = ST_RUN;
                    cnt_d   = load_val;
                end
            end
            ST_RUN: begin
                if (load) begin
                    cnt_d = load_val;
                end else if (stop) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (last) begin
                        if (periodic) begin
                            cnt_d = reload_val;
                        end else begin
                            state_d = ST_IDLE;
                            cnt_d   = '0;
                        end
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        expire = 1'b0;
        remain = '0;
        unique case (state_q)
            ST_IDLE: begin
                expire = 1'b0;
                remain = '0;
            end
            ST_RUN: begin
                expire = tick && last && !load && !stop;
                remain = cnt_q;
            end
            default: begin
                expire = 1'b0;
                remain = '0;
            end
        endcase
    end

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> remain == $past(load_val));

    // R4
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && !load && !stop && !last)
            |=> remain == $past(cnt_q) - CW'(1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !tick && !load && !stop) |=> $stable(remain));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> remain == $past(reload_val));

    // R8
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> (remain == '0 && !expire));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (remain == '0 && !expire));
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (set) begin
            irq <= 1'b1;
        end else if (clr) begin
            irq <= 1'b0;
        end
    end

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);

    // R9
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !irq);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> irq == $past(irq));
endmodule

// File: rtl/cd_timer.sv
module cd_timer #(
    parameter int CFG_W   = 64,
    parameter int CNT_HI  = 47,
    parameter int CNT_LO  = 2,
    parameter int EN_BIT  = 0,
    parameter int PER_BIT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               tick_en,
    input  logic               irq_clr,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic [CNT_HI:0]    remain,
    output logic               irq
);
    localparam int CW = CNT_HI + 1;

    logic [CFG_W-1:0] cfg_q;
    logic [CW-1:0]    load_val, reload_val;
    logic             load, stop, expire, periodic;

    assign load       = cfg_we &  cfg_wdata[EN_BIT];
    assign stop       = cfg_we & ~cfg_wdata[EN_BIT];
    assign load_val   = {cfg_wdata[CNT_HI:CNT_LO], {CNT_LO{1'b0}}};
    assign reload_val = {cfg_q[CNT_HI:CNT_LO], {CNT_LO{1'b0}}};
    assign periodic   = cfg_q[PER_BIT];
    assign cfg_rdata  = cfg_q;

    cdt_cfg_reg #(.CFG_W(CFG_W), .EN_BIT(EN_BIT)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .drop_en (expire & ~periodic),
        .cfg_q   (cfg_q)
    );

    cdt_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .stop       (stop),
        .load_val   (load_val),
        .reload_val (reload_val),
        .periodic   (periodic),
        .tick       (tick_en),
        .expire     (expire),
        .remain     (remain)
    );

    cdt_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (irq_clr),
        .irq   (irq)
    );

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic) |=> (remain == '0 && !cfg_rdata[EN_BIT]));
endmodule

// File: tb/sim_cd_timer.sv
module sim_cd_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic        tick_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic [63:0] cfg_rdata;
    logic [47:0] remain;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_cfg = '0;
    logic [47:0] m_cnt = '0;
    logic        m_run = 1'b0;
    logic        m_irq = 1'b0;

    always #2 clk = ~clk;

    cd_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tick_en(tick_en), .irq_clr(irq_clr), .cfg_rdata(cfg_rdata),
        .remain(remain), .irq(irq)
    );

    function automatic logic [47:0] masked(input logic [63:0] w);
        return {w[47:2], 2'b00};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference update from the requirements, using pre-edge values
    task automatic model(input logic we, input logic [63:0] wd, input logic tk, input logic clr);
        logic ex;
        ex = 1'b0;
        if (we) begin
            m_cfg = wd;
            m_run = wd[0];
            m_cnt = wd[0] ? masked(wd) : 48'd0;
        end else if (m_run && tk) begin
            if (m_cnt <= 48'd1) begin
                ex = 1'b1;
                if (m_cfg[1]) m_cnt = masked(m_cfg);
                else begin
                    m_cnt = 48'd0;
                    m_run = 1'b0;
                    m_cfg[0] = 1'b0;
                end
            end else begin
                m_cnt = m_cnt - 48'd1;
            end
        end
        if (ex) m_irq = 1'b1;
        else if (clr) m_irq = 1'b0;
    endtask

    task automatic step(input string tag, input logic we, input logic [63:0] wd,
                        input logic tk, input logic clr);
        cfg_we = we; cfg_wdata = wd; tick_en = tk; irq_clr = clr;
        @(posedge clk);
        model(we, wd, tk, clr);
        @(negedge clk);
        cfg_we = 1'b0; tick_en = 1'b0; irq_clr = 1'b0;
        check({tag, " cfg"}, cfg_rdata, m_cfg);
        check({tag, " remain"}, {16'd0, remain}, {16'd0, m_cnt});
        check({tag, " irq"}, {63'd0, irq}, {63'd0, m_irq});
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, '0, 1'b1, 1'b0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 cfg", cfg_rdata, 64'd0);
        check("R1 remain", {16'd0, remain}, 64'd0);
        check("R1 irq", {63'd0, irq}, 64'd0);
        step("R10 idle tick", 1'b0, '0, 1'b1, 1'b0);

        // R2 R3: periodic, count 0x14, high bits stored
        step("R2 R3 arm", 1'b1, 64'hABCD_0000_0000_0017, 1'b0, 1'b0);
        check("R3 remain", {16'd0, remain}, 64'd20);
        step("R4 hold", 1'b0, '0, 1'b0, 1'b0);
        step("R4 hold", 1'b0, '0, 1'b0, 1'b0);
        ticks("R4 count", 19);
        check("R4 one left", {16'd0, remain}, 64'd1);
        ticks("R5 R6 expire", 1);
        check("R6 reload", {16'd0, remain}, 64'd20);
        check("R9 irq set", {63'd0, irq}, 64'd1);
        step("R9 clear", 1'b0, '0, 1'b0, 1'b1);
        check("R9 cleared", {63'd0, irq}, 64'd0);
        ticks("R4 count", 19);
        step("R9 clr vs expire", 1'b0, '0, 1'b1, 1'b1);
        check("R9 expire wins", {63'd0, irq}, 64'd1);
        step("R9 clear", 1'b0, '0, 1'b0, 1'b1);

        // R3: write and tick in the same cycle; write wins
        step("R3 restart", 1'b1, 64'h0000_0000_0000_0023, 1'b1, 1'b0);
        check("R3 restart remain", {16'd0, remain}, 64'd32);

        // R7: one-shot count 8
        step("R7 arm", 1'b1, 64'h9, 1'b0, 1'b0);
        ticks("R7 run", 8);
        check("R7 cfg en cleared", cfg_rdata, 64'h8);
        check("R7 stopped", {16'd0, remain}, 64'd0);
        check("R7 irq", {63'd0, irq}, 64'd1);
        step("R9 clear", 1'b0, '0, 1'b0, 1'b1);
        ticks("R10 stopped ticks", 20);
        check("R10 irq quiet", {63'd0, irq}, 64'd0);

        // R8: halt mid-count
        step("R8 arm", 1'b1, 64'h41, 1'b0, 1'b0);
        ticks("R8 run", 5);
        check("R8 remain 59", {16'd0, remain}, 64'd59);
        step("R8 halt", 1'b1, 64'h40, 1'b1, 1'b0);
        check("R8 remain zero", {16'd0, remain}, 64'd0);
        ticks("R8 no expiry", 100);
        check("R8 irq low", {63'd0, irq}, 64'd0);

        // R5: zero count, bits 1:0 excluded
        step("R5 arm zero", 1'b1, 64'h3, 1'b0, 1'b0);
        check("R5 remain", {16'd0, remain}, 64'd0);
        ticks("R5 first tick", 1);
        check("R5 irq", {63'd0, irq}, 64'd1);
        step("R9 clear", 1'b0, '0, 1'b0, 1'b1);
        ticks("R5 periodic zero", 3);

        // R2: high bits ignored for count
        step("R2 high bits", 1'b1, 64'hFFFF_0000_0000_0005, 1'b0, 1'b0);
        check("R2 count", {16'd0, remain}, 64'd4);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic        we, tk, clr;
            logic [63:0] wd;
            we  = ($urandom_range(0, 99) < 3);
            tk  = ($urandom_range(0, 99) < 70);
            clr = ($urandom_range(0, 99) < 5);
            wd  = {$urandom(), 26'd0, 6'($urandom())};
            step("R3 R4 R6 R7 R9 random", we, wd, tk, clr);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule